// File: doc/BRIEF.md
# Write-Through Data Cache with Store FIFO

This block is a direct-mapped data cache placed between a processor load/store port and a slower memory. Every store goes to memory. A store that hits also updates the cached copy of that word. A store that misses leaves the cache as it is and is only forwarded. Stores pass through a small first-in first-out store queue, so a store costs the processor no memory latency unless the queue is already full. The queue drains one word at a time on a dedicated memory write port while the processor goes on working.

The cache holds 256 lines of four 32-bit words. The processor presents a byte address with a read or a write strobe and holds it while the stall output is high. A load hit returns data in the same cycle. A load miss first waits until every queued store has reached memory. It then requests the aligned block on the refill port, takes the four words in ascending order, installs the line and returns the requested word.

Top module: `wt_cache_top`

## Requirements
- R1: After reset every line is invalid, `cpu_stall`, `mem_wvalid` and `fill_req` are low, and the first load to any address is a miss.
- R2: Address bits [11:4] select the line, bits [3:2] select the word, bits [31:12] form the tag, and `fill_addr` during a refill equals the load address with bits [3:0] cleared.
- R3: A load miss with an empty store queue keeps `cpu_stall` high for exactly 5 cycles: one lookup cycle and four refill beats, taken in word order 0 to 3. It then returns the requested word, and the other three words of the block hit afterwards.
- R4: A load hit returns the cached word with `cpu_stall` low in the same cycle and raises no `fill_req`.
- R5: A store hit updates the cached word, so a later load to it hits and returns the new value, and the store is also queued for memory.
- R6: A store miss allocates no line, so a later load to that address misses. That load returns the stored value once the value has reached memory.
- R7: Every accepted store appears exactly once on the memory write port, in issue order, with its address and data held stable while `mem_wready` is low.
- R8: A store is accepted without stall while the queue holds fewer than 4 entries, and it stalls while the queue is full.
- R9: `fill_req` is never high while a queued store is pending (`mem_wvalid` high). A load miss waits, stalled, until the queue is empty.
- R10: Two blocks with the same index and different tags evict each other, so alternating loads to them all miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 32 | Processor byte address |
| cpu_rd | input | 1 | Load strobe, held until stall is low |
| cpu_wr | input | 1 | Store strobe, held until stall is low |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when cpu_rd is high and cpu_stall is low |
| cpu_stall | output | 1 | Processor must hold its request |
| mem_wvalid | output | 1 | Queued store available for memory |
| mem_wready | input | 1 | Memory takes the store word this cycle |
| mem_waddr | output | 32 | Store word address toward memory |
| mem_wdata | output | 32 | Store data toward memory |
| fill_req | output | 1 | Block refill in progress |
| fill_addr | output | 32 | Block-aligned refill address |
| fill_valid | input | 1 | Refill word present this cycle |
| fill_data | input | 32 | Refill word, ascending word order |

## Verification
The properties assume the processor never raises load and store together, and that it holds address, strobe and store data unchanged while stall is high. They also assume memory sends refill words only while a refill is requested. The bench drives every request from a single task, which keeps the strobes one-hot and stable until the design releases them. Its memory responder answers only while `fill_req` is high, and it changes its ready input only between clock edges.

// File: rtl/wtc_pkg.sv
package wtc_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_DRAIN = 2'd1,
      ST_FILL  = 2'd2
   } ctl_state_e;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/wtc_wbuf.sv
module wtc_wbuf #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int DEPTH = 4,
   localparam int PW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic [AW-1:0] push_addr,
   input  logic [DW-1:0] push_data,
   input  logic          pop,
   output logic          full,
   output logic          empty,
   output logic [AW-1:0] head_addr,
   output logic [DW-1:0] head_data
);

   logic [AW-1:0] addr_q [DEPTH];
   logic [DW-1:0] data_q [DEPTH];
   logic [PW-1:0] wr_ptr_q, rd_ptr_q;
   logic [PW:0]   cnt_q;
   logic          push_ok, pop_ok;

   assign full    = (cnt_q == (PW+1)'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign push_ok = push & ~full;
   assign pop_ok  = pop & ~empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr_q <= '0;
         rd_ptr_q <= '0;
         cnt_q    <= '0;
      end else begin
         if (push_ok) wr_ptr_q <= wr_ptr_q + 1'b1;
         if (pop_ok)  rd_ptr_q <= rd_ptr_q + 1'b1;
         cnt_q <= cnt_q + (PW+1)'(push_ok) - (PW+1)'(pop_ok);
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         addr_q[wr_ptr_q] <= push_addr;
         data_q[wr_ptr_q] <= push_data;
      end
   end

   assign head_addr = addr_q[rd_ptr_q];
   assign head_data = data_q[rd_ptr_q];

endmodule

// File: rtl/wtc_lines.sv
module wtc_lines #(
   parameter int LINES      = 256,
   parameter int LINE_WORDS = 4,
   parameter int TAG_W      = 20,
   parameter int DW         = 32,
   localparam int IDX_W     = $clog2(LINES),
   localparam int WOFF_W    = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WOFF_W-1:0] rd_woff,
   input  logic [TAG_W-1:0]  tag,
   output logic              hit,
   output logic [DW-1:0]     rd_word,
   input  logic              wr_en,
   input  logic [WOFF_W-1:0] wr_woff,
   input  logic [DW-1:0]     wr_word,
   input  logic              install
);

   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];
   logic [DW-1:0]    lane_out [LINE_WORDS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       valid_q      <= '0;
      else if (install) valid_q[idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (install) tag_q[idx] <= tag;
   end

   for (genvar w = 0; w < LINE_WORDS; w++) begin : g_lane
      logic [DW-1:0] word_q [LINES];
      always_ff @(posedge clk) begin
         if (wr_en && (wr_woff == WOFF_W'(w))) word_q[idx] <= wr_word;
      end
      assign lane_out[w] = word_q[idx];
   end

   assign hit     = valid_q[idx] & (tag_q[idx] == tag);
   assign rd_word = lane_out[rd_woff];

endmodule

// File: rtl/wtc_ctrl.sv
module wtc_ctrl
   import wtc_pkg::*;
#(
   parameter int LINE_WORDS = 4,
   localparam int WOFF_W    = $clog2(LINE_WORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_req,
   input  logic              hit,
   input  logic              wb_empty,
   input  logic              fill_valid,
   output logic              fill_req,
   output logic              fill_we,
   output logic              fill_done,
   output logic [WOFF_W-1:0] fill_beat,
   output logic              ld_stall
);

   ctl_state_e        state_q, state_d;
   logic [WOFF_W-1:0] beat_q;

   assign fill_req  = (state_q == ST_FILL);
   assign fill_we   = fill_req & fill_valid;
   assign fill_done = fill_we & (beat_q == WOFF_W'(LINE_WORDS - 1));
   assign fill_beat = beat_q;
   assign ld_stall  = ld_req & ((state_q != ST_IDLE) | ~hit);

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE:  if (ld_req && !hit) state_d = wb_empty ? ST_FILL : ST_DRAIN;
         ST_DRAIN: if (wb_empty)       state_d = ST_FILL;
         ST_FILL:  if (fill_done)      state_d = ST_IDLE;
         default:                      state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         beat_q  <= '0;
      end else begin
         state_q <= state_d;
         if (fill_we) beat_q <= beat_q + 1'b1;
      end
   end

endmodule

// File: rtl/wt_cache_top.sv
module wt_cache_top
   import wtc_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int LINES      = 256,
   parameter int LINE_WORDS = 4,
   parameter int WBUF_DEPTH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   output logic              cpu_stall,
   output logic              mem_wvalid,
   input  logic              mem_wready,
   output logic [ADDR_W-1:0] mem_waddr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              fill_req,
   output logic [ADDR_W-1:0] fill_addr,
   input  logic              fill_valid,
   input  logic [DATA_W-1:0] fill_data
);

   localparam int BOFF_W = $clog2(DATA_W / 8);
   localparam int WOFF_W = $clog2(LINE_WORDS);
   localparam int IDX_W  = $clog2(LINES);
   localparam int LOW_W  = WOFF_W + BOFF_W;
   localparam int TAG_W  = ADDR_W - IDX_W - LOW_W;

   if (!is_pow2(LINES) || !is_pow2(LINE_WORDS)) begin : g_bad_geom
      $error("LINES and LINE_WORDS must be powers of two");
   end
   if (!is_pow2(WBUF_DEPTH) || WBUF_DEPTH < 2) begin : g_bad_depth
      $error("WBUF_DEPTH must be a power of two of at least 2");
   end
   if (DATA_W % 8 != 0 || TAG_W < 1) begin : g_bad_width
      $error("address and data widths do not fit the geometry");
   end

   logic [TAG_W-1:0]  a_tag;
   logic [IDX_W-1:0]  a_idx;
   logic [WOFF_W-1:0] a_woff;
   logic [BOFF_W-1:0] unused_boff;

   assign a_tag       = cpu_addr[ADDR_W-1 -: TAG_W];
   assign a_idx       = cpu_addr[LOW_W +: IDX_W];
   assign a_woff      = cpu_addr[BOFF_W +: WOFF_W];
   assign unused_boff = cpu_addr[BOFF_W-1:0];

   logic              hit, wb_full, wb_empty, store_acc;
   logic              fill_we, fill_done, ld_stall;
   logic [WOFF_W-1:0] fill_beat;
   logic              line_we;
   logic [WOFF_W-1:0] line_woff;
   logic [DATA_W-1:0] line_wdata;

   assign store_acc  = cpu_wr & ~wb_full;
   assign line_we    = fill_we | (store_acc & hit);
   assign line_woff  = fill_we ? fill_beat : a_woff;
   assign line_wdata = fill_we ? fill_data : cpu_wdata;

   wtc_lines #(
      .LINES(LINES), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .DW(DATA_W)
   ) u_lines (
      .clk(clk), .rst_n(rst_n),
      .idx(a_idx), .rd_woff(a_woff), .tag(a_tag),
      .hit(hit), .rd_word(cpu_rdata),
      .wr_en(line_we), .wr_woff(line_woff), .wr_word(line_wdata),
      .install(fill_done)
   );

   wtc_wbuf #(
      .AW(ADDR_W), .DW(DATA_W), .DEPTH(WBUF_DEPTH)
   ) u_wbuf (
      .clk(clk), .rst_n(rst_n),
      .push(cpu_wr), .push_addr(cpu_addr), .push_data(cpu_wdata),
      .pop(mem_wready),
      .full(wb_full), .empty(wb_empty),
      .head_addr(mem_waddr), .head_data(mem_wdata)
   );

   wtc_ctrl #(
      .LINE_WORDS(LINE_WORDS)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .ld_req(cpu_rd), .hit(hit), .wb_empty(wb_empty), .fill_valid(fill_valid),
      .fill_req(fill_req), .fill_we(fill_we), .fill_done(fill_done),
      .fill_beat(fill_beat), .ld_stall(ld_stall)
   );

   assign mem_wvalid = ~wb_empty;
   assign fill_addr  = {a_tag, a_idx, {LOW_W{1'b0}}};
   assign cpu_stall  = ld_stall | (cpu_wr & wb_full);

endmodule

// File: rtl/wtc_cache_chk.sv
module wtc_cache_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_rd,
   input logic              cpu_wr,
   input logic              cpu_stall,
   input logic              fill_req,
   input logic [ADDR_W-1:0] fill_addr,
   input logic              mem_wvalid,
   input logic              mem_wready,
   input logic [ADDR_W-1:0] mem_waddr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              wb_full
);

   // R9: a refill never overlaps a pending queued store
   a_r9_fill_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> !mem_wvalid);

   // R7: a store offered to memory is held until taken
   a_r7_store_held: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wvalid && !mem_wready) |=> (mem_wvalid && $stable(mem_waddr) && $stable(mem_wdata)));

   // R8: a lone store stalls only while the queue is full
   a_r8_stall_only_full: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && !cpu_rd && cpu_stall) |-> wb_full);

   // R8: a store meeting a full queue is held off
   a_r8_full_stalls: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && wb_full) |-> cpu_stall);

   // R3: the refill block address does not move during a refill
   a_r3_fill_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && $past(fill_req)) |-> $stable(fill_addr));

   // R4: a released load is never accompanied by a refill
   a_r4_hit_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rd && !cpu_stall) |-> !fill_req);

endmodule

bind wt_cache_top wtc_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
   .cpu_stall(cpu_stall), .fill_req(fill_req), .fill_addr(fill_addr),
   .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
   .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wb_full(wb_full)
);

// File: tb/wt_cache_top_tb.sv
module wt_cache_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] cpu_addr = '0;
   logic        cpu_rd = 1'b0;
   logic        cpu_wr = 1'b0;
   logic [31:0] cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_stall;
   logic        mem_wvalid;
   logic        mem_wready = 1'b1;
   logic [31:0] mem_waddr, mem_wdata;
   logic        fill_req;
   logic [31:0] fill_addr;
   logic        fill_valid = 1'b0;
   logic [31:0] fill_data = '0;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   wt_cache_top dut_i (
      .clk(clk), .rst_n(rst_n),
      .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
      .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
      .mem_wvalid(mem_wvalid), .mem_wready(mem_wready),
      .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
      .fill_req(fill_req), .fill_addr(fill_addr),
      .fill_valid(fill_valid), .fill_data(fill_data)
   );

   logic [31:0] mem_model [logic [31:0]];
   logic [31:0] ref_model [logic [31:0]];
   logic [63:0] exp_q [$];
   logic [31:0] last_fill_addr = '0;
   int          beat = 0;

   function automatic logic [31:0] init_val(input logic [31:0] a);
      return {a[15:0] ^ 16'h5A5A, a[31:16] ^ 16'hC3C3};
   endfunction

   function automatic logic [31:0] mem_rd(input logic [31:0] a);
      return mem_model.exists(a) ? mem_model[a] : init_val(a);
   endfunction

   function automatic logic [31:0] ref_rd(input logic [31:0] a);
      return ref_model.exists(a) ? ref_model[a] : init_val(a);
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
      end
   endtask

   // monitor: scoreboard for the memory write port (R7)
   always @(negedge clk) begin
      if (rst_n && mem_wvalid && mem_wready) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R7", "unexpected memory write", mem_waddr, 32'h0);
         end else begin
            logic [63:0] e;
            e = exp_q.pop_front();
            check(mem_waddr == e[63:32], "R7", "write address", mem_waddr, e[63:32]);
            check(mem_wdata == e[31:0],  "R7", "write data",    mem_wdata, e[31:0]);
         end
         mem_model[{mem_waddr[31:2], 2'b00}] = mem_wdata;
      end
   end

   // refill responder: one word per cycle in ascending order
   always @(negedge clk) begin
      if (!fill_req) begin
         fill_valid = 1'b0;
         beat = 0;
      end else begin
         if (fill_valid) beat++;
         last_fill_addr = fill_addr;
         fill_valid = 1'b1;
         fill_data = mem_rd(fill_addr + 32'(beat * 4));
      end
   end

   task automatic do_load(input logic [31:0] a, output int stalls, output logic [31:0] d);
      @(posedge clk); #1;
      cpu_addr = a; cpu_rd = 1'b1;
      stalls = 0;
      @(negedge clk);
      while (cpu_stall) begin
         stalls++;
         @(negedge clk);
      end
      d = cpu_rdata;
      @(posedge clk); #1;
      cpu_rd = 1'b0;
   endtask

   task automatic do_store(input logic [31:0] a, input logic [31:0] v, output int stalls);
      @(posedge clk); #1;
      cpu_addr = a; cpu_wdata = v; cpu_wr = 1'b1;
      stalls = 0;
      @(negedge clk);
      while (cpu_stall) begin
         stalls++;
         @(negedge clk);
      end
      exp_q.push_back({{a[31:2], 2'b00}, v});
      ref_model[{a[31:2], 2'b00}] = v;
      @(posedge clk); #1;
      cpu_wr = 1'b0;
   endtask

   task automatic wait_drain();
      @(negedge clk);
      while (mem_wvalid) @(negedge clk);
   endtask

   initial begin
      int s;
      logic [31:0] d;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      check(!cpu_stall, "R1", "stall after reset", 32'(cpu_stall), 0);
      check(!mem_wvalid, "R1", "write valid after reset", 32'(mem_wvalid), 0);
      check(!fill_req, "R1", "refill after reset", 32'(fill_req), 0);
      rst_n = 1'b1;

      // R1/R3/R2: first load misses, 5 stall cycles, aligned block address
      do_load(32'h0000_1236, s, d);
      check(s == 5, "R3", "miss stall cycles", 32'(s), 5);
      check(d == ref_rd(32'h0000_1234), "R3", "miss data", d, ref_rd(32'h0000_1234));
      check(last_fill_addr == 32'h0000_1230, "R2", "refill address", last_fill_addr, 32'h0000_1230);

      // R4: hit on same word and on the other words of the block
      do_load(32'h0000_1234, s, d);
      check(s == 0, "R4", "hit stall", 32'(s), 0);
      check(d == ref_rd(32'h0000_1234), "R4", "hit data", d, ref_rd(32'h0000_1234));
      for (int w = 0; w < 4; w++) begin
         do_load(32'h0000_1230 + 32'(w * 4), s, d);
         check(s == 0, "R3", "block word hit", 32'(s), 0);
         check(d == ref_rd(32'h0000_1230 + 32'(w * 4)), "R3", "block word data", d,
               ref_rd(32'h0000_1230 + 32'(w * 4)));
      end

      // R5: store hit updates cached word and goes to memory
      do_store(32'h0000_1238, 32'hDEAD_0001, s);
      check(s == 0, "R5", "store hit stall", 32'(s), 0);
      do_load(32'h0000_1238, s, d);
      check(s == 0, "R5", "load after store hit is a hit", 32'(s), 0);
      check(d == 32'hDEAD_0001, "R5", "updated word", d, 32'hDEAD_0001);
      wait_drain();
      check(mem_rd(32'h0000_1238) == 32'hDEAD_0001, "R5", "memory copy",
            mem_rd(32'h0000_1238), 32'hDEAD_0001);

      // R6: store miss does not allocate
      do_store(32'h0004_5678, 32'hBEEF_0002, s);
      wait_drain();
      do_load(32'h0004_5678, s, d);
      check(s == 5, "R6", "load after store miss misses", 32'(s), 5);
      check(d == 32'hBEEF_0002, "R6", "value from memory", d, 32'hBEEF_0002);

      // R8: four stores absorbed with memory blocked, fifth stalls
      mem_wready = 1'b0;
      for (int i = 0; i < 4; i++) begin
         do_store(32'h0010_0000 + 32'(i * 16), 32'hA000_0000 + 32'(i), s);
         check(s == 0, "R8", "store into non-full queue", 32'(s), 0);
      end
      @(posedge clk); #1;
      cpu_addr = 32'h0010_0100; cpu_wdata = 32'hA000_0004; cpu_wr = 1'b1;
      repeat (3) begin
         @(negedge clk);
         check(cpu_stall, "R8", "store into full queue stalls", 32'(cpu_stall), 1);
      end
      @(posedge clk); #1;
      mem_wready = 1'b1;
      @(negedge clk);
      while (cpu_stall) @(negedge clk);
      exp_q.push_back({32'h0010_0100, 32'hA000_0004});
      ref_model[32'h0010_0100] = 32'hA000_0004;
      @(posedge clk); #1;
      cpu_wr = 1'b0;
      wait_drain();

      // R9: load miss waits for the queue to drain, then sees the stored value
      mem_wready = 1'b0;
      do_store(32'h0020_0044, 32'h5555_AAAA, s);
      @(posedge clk); #1;
      cpu_addr = 32'h0020_0044; cpu_rd = 1'b1;
      repeat (4) begin
         @(negedge clk);
         check(!fill_req && cpu_stall, "R9", "refill held while store pending",
               {30'b0, fill_req, cpu_stall}, 32'h1);
      end
      @(posedge clk); #1;
      mem_wready = 1'b1;
      @(negedge clk);
      while (cpu_stall) @(negedge clk);
      check(cpu_rdata == 32'h5555_AAAA, "R9", "load returns drained value",
            cpu_rdata, 32'h5555_AAAA);
      @(posedge clk); #1;
      cpu_rd = 1'b0;

      // R10: conflicting blocks evict each other
      wait_drain();
      do_load(32'h0000_2040, s, d);
      check(s == 5, "R10", "first block miss", 32'(s), 5);
      do_load(32'h0000_3040, s, d);
      check(s == 5, "R10", "conflicting block miss", 32'(s), 5);
      check(d == ref_rd(32'h0000_3040), "R10", "conflict data", d, ref_rd(32'h0000_3040));
      do_load(32'h0000_2040, s, d);
      check(s == 5, "R10", "evicted block misses again", 32'(s), 5);
      check(d == ref_rd(32'h0000_2040), "R10", "reload data", d, ref_rd(32'h0000_2040));

      // R7: every store reached memory
      wait_drain();
      repeat (2) @(negedge clk);
      check(exp_q.size() == 0, "R7", "stores left undelivered", 32'(exp_q.size()), 0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule